// File: doc/BRIEF.md
# LIN Slave Baud Auto-Calibrator

This block recovers a LIN slave's bit rate from the synch field that follows a synch break. When auto-sync is enabled, a break-detected strobe arms a measurement. The block then counts system clock cycles from the first to the fifth falling edge on the receive line. For the 0x55 synch byte this interval covers eight bit times. The count is rounded into an unsigned fixed-point divider with an 8-bit integer part and a 4-bit fractional part.

Three divider registers are kept. The nominal divider holds what software wrote. The measured divider holds the last successful result. The active divider drives a fractional accumulator that emits a 16x-oversampling baud tick, shared by transmit and receive. The busy flag stays high while a measurement is armed or running, and the frame receiver holds off for that time. An integer-part write by software wins over a measurement that completes in the same cycle.

The measurement controller is a three-state machine:
- `S_IDLE`: nothing armed. It moves to `S_ARMED` on a break strobe while auto-sync is enabled.
- `S_ARMED`: waiting for the first falling edge. It moves to `S_MEASURE` on that edge. It returns to `S_IDLE` if auto-sync is withdrawn. A new break keeps it in `S_ARMED`.
- `S_MEASURE`: counting cycles. It returns to `S_IDLE` on the fifth falling edge (done), on counter saturation (error), or when auto-sync is withdrawn (abort). A new break re-arms it to `S_ARMED`.

Top module: `lin_baud_autocal`

## Requirements
- R1: After reset, `div_nom` and `div_act` both equal the nominal reset value (0x0A0, that is 10.0). `div_meas` is 0, and `meas_busy` and `meas_err` are low.
- R2: A `brk_det` pulse with `autosync_en` high raises `meas_busy` in the next cycle and clears `meas_err`. A `brk_det` pulse with `autosync_en` low is ignored: `meas_busy` stays low and `div_act` is unchanged.
- R3: Let T be the number of clock cycles from the first to the fifth falling edge of `rxd`. When the fifth edge is seen, `meas_busy` falls, and `div_meas` and `div_act` both become min((T+4)>>3, 4095). Otherwise `div_act` changes only on an integer-part write.
- R4: The conversion rounds half up at 1/16 steps: T=1283 gives 0x0A0, and T=1284 gives 0x0A1.
- R5: If T would exceed 32768, the 15-bit counter saturates. The measurement then ends with `meas_err` high, and `div_meas` and `div_act` keep their previous values.
- R6: A write with `wr_sel`=1 (integer part) sets `div_nom[11:4]` to `wr_data`. In the next cycle `div_act` equals {`wr_data`, `div_nom[3:0]`}.
- R7: A write with `wr_sel`=0 (fraction part) sets `div_nom[3:0]` to `wr_data[3:0]` and leaves `div_act` unchanged.
- R8: If an integer-part write and a completing measurement land in the same cycle, `div_act` takes the nominal value. `div_meas` still takes the measured result.
- R9: `baud_tick` pulses on average once every `div_act`/16 clock cycles. Any 16*k consecutive ticks span exactly k*`div_act` cycles.
- R10: A `div_act` below 0x010 (1.0) is treated as 1.0, so `baud_tick` is high every cycle.
- R11: Dropping `autosync_en` while `meas_busy` is high drops `meas_busy` in the next cycle. No divider is updated and no error is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | LIN receive line (asynchronous) |
| brk_det | input | 1 | One-cycle strobe: synch break seen |
| autosync_en | input | 1 | Enables automatic measurement |
| wr_en | input | 1 | Software write strobe |
| wr_sel | input | 1 | 1 = integer part, 0 = fraction part |
| wr_data | input | 8 | Write data |
| baud_tick | output | 1 | 16x oversampling tick |
| meas_busy | output | 1 | Measurement armed or running; receiver held |
| meas_err | output | 1 | Last measurement saturated |
| div_nom | output | 12 | Nominal divider (integer.fraction) |
| div_meas | output | 12 | Last measured divider |
| div_act | output | 12 | Active divider driving the tick |

## Verification
The measurement is driven with whole synch frames whose fifth edge is shifted by a few cycles. An exact multiple of eight separates integer recovery from rounding. Intervals of 1283 and 1284 cycles sit on either side of the rounding step. An interval of 32768 hits the upper clamp, and one of 33000 forces saturation and shows that the previous divider is kept. Divider writes land before, during and exactly at the completion cycle, which tells staged fraction writes apart from integer writes and confirms their priority. Tick spans are measured at integer, fractional and sub-unity dividers.

// File: rtl/lin_cal_pkg.sv
package lin_cal_pkg;
    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_ARMED   = 2'd1,
        S_MEASURE = 2'd2
    } meter_state_e;
endpackage

// File: rtl/lin_edge_sync.sv
module lin_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic fall
);
    logic [STAGES:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= {pipe_q[STAGES-1:0], line_in};
    end

    assign fall = pipe_q[STAGES] & ~pipe_q[STAGES-1];
endmodule

// File: rtl/lin_sync_meter.sv
module lin_sync_meter
    import lin_cal_pkg::*;
#(
    parameter int CNT_W  = 15,
    parameter int DIV_W  = 12,
    parameter int EDGES  = 5,
    parameter int SHIFT  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fall,
    input  logic             brk_det,
    input  logic             enable,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic [DIV_W-1:0] result
);
    localparam int EC_W = $clog2(EDGES);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [EC_W-1:0] LAST_IDX = EC_W'(EDGES - 2);

    meter_state_e      state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [EC_W-1:0]   edge_q;
    logic              err_q;
    logic              arm, fifth, sat;
    logic [CNT_W:0]    total, rnd_full;

    assign arm   = brk_det & enable;
    assign fifth = (state_q == S_MEASURE) && enable && !arm && fall && (edge_q == LAST_IDX);
    assign sat   = (state_q == S_MEASURE) && enable && !arm && !fifth && (cnt_q == CNT_MAX);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (arm) state_d = S_ARMED;
            S_ARMED: begin
                if (!enable)   state_d = S_IDLE;
                else if (arm)  state_d = S_ARMED;
                else if (fall) state_d = S_MEASURE;
            end
            S_MEASURE: begin
                if (!enable)           state_d = S_IDLE;
                else if (arm)          state_d = S_ARMED;
                else if (fifth || sat) state_d = S_IDLE;
            end
            default:   state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            edge_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q != S_MEASURE) begin
                cnt_q  <= '0;
                edge_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
                if (fall) edge_q <= edge_q + 1'b1;
            end
            if (arm)      err_q <= 1'b0;
            else if (sat) err_q <= 1'b1;
        end
    end

    always_comb begin
        total    = {1'b0, cnt_q} + 1'b1;
        rnd_full = (total + (CNT_W+1)'(1 << (SHIFT-1))) >> SHIFT;
        busy     = (state_q != S_IDLE);
        done     = fifth;
        err      = err_q;
        result   = (|rnd_full[CNT_W:DIV_W]) ? '1 : rnd_full[DIV_W-1:0];
    end
endmodule

// File: rtl/lin_div_regs.sv
module lin_div_regs #(
    parameter int INT_W  = 8,
    parameter int FRAC_W = 4,
    parameter logic [INT_W+FRAC_W-1:0] NOM_RESET = 12'h0A0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    wr_sel,
    input  logic [INT_W-1:0]        wr_data,
    input  logic                    meas_done,
    input  logic [INT_W+FRAC_W-1:0] meas_val,
    output logic [INT_W+FRAC_W-1:0] nom_q,
    output logic [INT_W+FRAC_W-1:0] meas_q,
    output logic [INT_W+FRAC_W-1:0] act_q
);
    logic int_wr, frac_wr;
    assign int_wr  = wr_en & wr_sel;
    assign frac_wr = wr_en & ~wr_sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nom_q  <= NOM_RESET;
            meas_q <= '0;
            act_q  <= NOM_RESET;
        end else begin
            if (int_wr)       nom_q[INT_W+FRAC_W-1:FRAC_W] <= wr_data;
            else if (frac_wr) nom_q[FRAC_W-1:0] <= wr_data[FRAC_W-1:0];
            if (meas_done)    meas_q <= meas_val;
            if (int_wr)         act_q <= {wr_data, nom_q[FRAC_W-1:0]};
            else if (meas_done) act_q <= meas_val;
        end
    end
endmodule

// File: rtl/lin_baud_tick.sv
module lin_baud_tick #(
    parameter int DIV_W = 12,
    parameter int OSR   = 16,
    parameter int MIN_DIV = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divider,
    output logic             tick
);
    localparam int ACC_W = DIV_W + 1;

    logic [ACC_W-1:0] acc_q, sum, eff;
    logic             hit;

    always_comb begin
        eff = (divider < DIV_W'(MIN_DIV)) ? ACC_W'(MIN_DIV) : {1'b0, divider};
        sum = acc_q + ACC_W'(OSR);
        hit = (sum >= eff);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            tick  <= 1'b0;
        end else begin
            acc_q <= hit ? (sum - eff) : sum;
            tick  <= hit;
        end
    end
endmodule

// File: rtl/lin_baud_autocal.sv
module lin_baud_autocal #(
    parameter int INT_W  = 8,
    parameter int FRAC_W = 4,
    parameter int CNT_W  = 15,
    parameter logic [INT_W+FRAC_W-1:0] NOM_RESET = 12'h0A0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rxd,
    input  logic                    brk_det,
    input  logic                    autosync_en,
    input  logic                    wr_en,
    input  logic                    wr_sel,
    input  logic [INT_W-1:0]        wr_data,
    output logic                    baud_tick,
    output logic                    meas_busy,
    output logic                    meas_err,
    output logic [INT_W+FRAC_W-1:0] div_nom,
    output logic [INT_W+FRAC_W-1:0] div_meas,
    output logic [INT_W+FRAC_W-1:0] div_act
);
    localparam int DIV_W = INT_W + FRAC_W;
    localparam int OSR   = 16;

    logic             rx_fall, m_done;
    logic [DIV_W-1:0] m_val;

    lin_edge_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .line_in(rxd), .fall(rx_fall)
    );

    lin_sync_meter #(.CNT_W(CNT_W), .DIV_W(DIV_W), .EDGES(5), .SHIFT(3)) u_meter (
        .clk(clk), .rst_n(rst_n), .fall(rx_fall), .brk_det(brk_det),
        .enable(autosync_en), .busy(meas_busy), .done(m_done),
        .err(meas_err), .result(m_val)
    );

    lin_div_regs #(.INT_W(INT_W), .FRAC_W(FRAC_W), .NOM_RESET(NOM_RESET)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .meas_done(m_done), .meas_val(m_val),
        .nom_q(div_nom), .meas_q(div_meas), .act_q(div_act)
    );

    lin_baud_tick #(.DIV_W(DIV_W), .OSR(OSR), .MIN_DIV(1 << FRAC_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .divider(div_act), .tick(baud_tick)
    );
endmodule

// File: rtl/lin_baud_autocal_chk.sv
module lin_baud_autocal_chk #(
    parameter int INT_W  = 8,
    parameter int FRAC_W = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    brk_det,
    input logic                    autosync_en,
    input logic                    wr_en,
    input logic                    wr_sel,
    input logic [INT_W-1:0]        wr_data,
    input logic                    baud_tick,
    input logic                    meas_busy,
    input logic                    meas_err,
    input logic [INT_W+FRAC_W-1:0] div_nom,
    input logic [INT_W+FRAC_W-1:0] div_act
);
    p_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_det && autosync_en) |=> meas_busy);

    p_ignore_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!meas_busy && !(brk_det && autosync_en)) |=> !meas_busy);

    p_act_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!meas_busy && !(wr_en && wr_sel)) |=> $stable(div_act));

    p_err_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(meas_err) |-> $fell(meas_busy));

    p_int_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel) |=> (div_act == {$past(wr_data), $past(div_nom[FRAC_W-1:0])}));

    p_frac_stage_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel && !meas_busy) |=> $stable(div_act));

    p_clamp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (div_act < (INT_W+FRAC_W)'(1 << FRAC_W)) |=> baud_tick);

    p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_busy && !autosync_en) |=> !meas_busy);
endmodule

bind lin_baud_autocal lin_baud_autocal_chk #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .brk_det(brk_det), .autosync_en(autosync_en),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .baud_tick(baud_tick),
    .meas_busy(meas_busy), .meas_err(meas_err), .div_nom(div_nom), .div_act(div_act)
);

// File: tb/lin_baud_autocal_test.sv
`timescale 1ns/1ps
module lin_baud_autocal_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rxd = 1'b1;
    logic        brk_det = 1'b0;
    logic        autosync_en = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        baud_tick, meas_busy, meas_err;
    logic [11:0] div_nom, div_meas, div_act;

    int applied = 0;
    int miscompares = 0;
    bit finished = 0;

    logic [11:0] m_nom = 12'h0A0, m_meas = 12'h000, m_act = 12'h0A0;
    logic [24:0] exp_q[$];

    always #2 clk = ~clk;

    lin_baud_autocal uut (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .brk_det(brk_det),
        .autosync_en(autosync_en), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .baud_tick(baud_tick), .meas_busy(meas_busy),
        .meas_err(meas_err), .div_nom(div_nom), .div_meas(div_meas),
        .div_act(div_act)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        applied++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Monitor: every end of a measurement is compared with the scoreboard head
    logic busy_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy_prev && !meas_busy) begin
                if (exp_q.size() == 0) begin
                    check("R3 unexpected end", {7'd0, meas_err, div_meas, div_act}, 32'hFFFFFFFF);
                end else begin
                    logic [24:0] e;
                    e = exp_q.pop_front();
                    check("R3/R5/R8 end {err,meas,act}", {7'd0, meas_err, div_meas, div_act}, {7'd0, e});
                end
            end
            busy_prev <= meas_busy;
        end
    end

    task automatic sw_write(bit sel, logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (sel) begin m_act = {d, m_nom[3:0]}; m_nom[11:4] = d; end
        else     m_nom[3:0] = d[3:0];
    endtask

    task automatic arm();
        brk_det = 1'b1;
        @(negedge clk);
        brk_det = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // Driver: one synch byte 0x55 with bit period p; fifth edge moved by tweak
    task automatic sync_field(int p, int tweak, bit conflict, logic [7:0] cdata);
        int t;
        logic [11:0] r;
        logic [10:0] frame;
        t = 8*p + tweak;
        if (t > 32768) begin
            exp_q.push_back({1'b1, m_meas, m_act});
        end else begin
            r = ((t + 4) >> 3) > 4095 ? 12'hFFF : 12'((t + 4) >> 3);
            m_meas = r;
            if (conflict) begin
                m_act = {cdata, m_nom[3:0]};
                m_nom[11:4] = cdata;
            end else m_act = r;
            exp_q.push_back({1'b0, m_meas, m_act});
        end
        arm();
        frame = {1'b1, 1'b1, 8'h55, 1'b0};
        for (int b = 0; b < 11; b++) begin
            int dur;
            rxd = frame[b];
            dur = (b == 7) ? p + tweak : p;
            for (int c = 0; c < dur; c++) begin
                if (conflict && b == 8 && c == 2) begin
                    wr_en = 1'b1; wr_sel = 1'b1; wr_data = cdata;
                end
                if (c == 3) wr_en = 1'b0;
                @(negedge clk);
            end
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic tick_span(int n, output int cycles);
        while (baud_tick !== 1'b1) @(negedge clk);
        cycles = 0;
        for (int k = 0; k < n; ) begin
            @(negedge clk);
            cycles++;
            if (baud_tick) k++;
        end
    endtask

    initial begin
        int span;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 div_nom", div_nom, 12'h0A0);
        check("R1 div_act", div_act, 12'h0A0);
        check("R1 div_meas", div_meas, 12'h000);
        check("R1 busy/err", {meas_busy, meas_err}, 2'b00);

        // R9 tick at 10.0
        repeat (20) @(negedge clk);
        tick_span(16, span);
        check("R9 span 16 ticks @10.0", span, 160);

        // R2 ignored break while disabled
        brk_det = 1'b1; @(negedge clk); brk_det = 1'b0;
        @(negedge clk);
        check("R2 ignored busy", meas_busy, 1'b0);
        check("R2 ignored act", div_act, m_act);

        autosync_en = 1'b1;
        brk_det = 1'b1; @(negedge clk); brk_det = 1'b0;
        check("R2 armed busy", meas_busy, 1'b1);
        // R11 withdraw enable while armed
        exp_q.push_back({1'b0, m_meas, m_act});
        autosync_en = 1'b0; @(negedge clk);
        check("R11 abort busy", meas_busy, 1'b0);
        check("R11 abort act", div_act, m_act);
        autosync_en = 1'b1;

        // R3 exact recovery, R4 rounding
        sync_field(160, 0, 0, 8'h00);
        check("R3 act 0x0A0", div_act, 12'h0A0);
        sync_field(200, 0, 0, 8'h00);
        check("R3 act 0x0C8", div_act, 12'h0C8);
        sync_field(160, 3, 0, 8'h00);
        check("R4 T=1283", div_act, 12'h0A0);
        sync_field(160, 4, 0, 8'h00);
        check("R4 T=1284", div_act, 12'h0A1);

        // R7 staged fraction write, R6 integer write
        sw_write(0, 8'h08);
        @(negedge clk);
        check("R7 act unchanged", div_act, 12'h0A1);
        check("R7 nom frac", div_nom[3:0], 4'h8);
        sw_write(1, 8'h05);
        check("R6 act", div_act, 12'h058);
        check("R6 nom", div_nom, 12'h058);

        // R9 fractional divider 5.5: 16 ticks -> 88 cycles
        repeat (20) @(negedge clk);
        tick_span(16, span);
        check("R9 span 16 ticks @5.5", span, 88);
        tick_span(160, span);
        check("R9 span 160 ticks @5.5", span, 880);

        // R8 conflict: integer write at the completion cycle
        sync_field(120, 0, 1, 8'h33);
        check("R8 act nominal", div_act, 12'h338);
        check("R8 meas", div_meas, 12'd120);

        // R10 clamp below 1.0
        sw_write(0, 8'h00);
        sw_write(1, 8'h00);
        repeat (2) @(negedge clk);
        span = 0;
        for (int c = 0; c < 8; c++) begin
            if (baud_tick) span++;
            @(negedge clk);
        end
        check("R10 tick every cycle", span, 8);

        // R3 upper clamp at T=32768
        sync_field(4096, 0, 0, 8'h00);
        check("R3 clamp 0xFFF", div_act, 12'hFFF);
        // R5 saturation keeps dividers
        sync_field(4125, 0, 0, 8'h00);
        check("R5 err", meas_err, 1'b1);
        check("R5 act kept", div_act, 12'hFFF);
        // R2 err cleared on arming, then a good result
        sync_field(96, 0, 0, 8'h00);
        check("R2 err cleared", meas_err, 1'b0);
        check("R3 act 0x060", div_act, 12'h060);

        check("R3 scoreboard drained", exp_q.size(), 0);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            applied++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
            $finish;
        end
    end
endmodule